// File: doc/BRIEF.md
# DC-only 4x4 tile reconstructor

This block rebuilds a 4x4 tile of pixels when the only non-zero transform coefficient of its residual is the DC term. It takes one signed DC coefficient and a bit-depth code. It turns the coefficient into one signed residual through two fixed-point scalings and a final rounding. It then adds that residual to each of the sixteen predicted pixels and clamps every sum to the pixel range of the selected depth.

Each coefficient arrives with a valid/ready handshake. The block needs two cycles to form the residual. Predicted pixels then stream in with a second handshake, two rows of four pixels per beat, and the reconstructed rows leave through a third handshake. The output beats come out in the order the input beats were taken. The block takes the next coefficient only after the second output beat of the tile has left.

Top module: `dcq_recon`

## Requirements
- R1: The residual is found in three steps. First, t1 = (dc*11585 + 8192) >>> 14. Second, t2 = (t1*11585 + 8192) >>> 14. Third, the residual is (t2 + 8) >>> 4. All three shifts are arithmetic.
- R2: Every pixel of the tile gets the same residual added, in both beats. Pixel i of a beat is held in bits [16*i+15:16*i]. Pixels 0-3 form the first row of the beat and pixels 4-7 form the second.
- R3: Any sum above (1<<bd)-1 is output as (1<<bd)-1.
- R4: Any sum below zero is output as 0.
- R5: A tile is exactly two input beats and two output beats. Output beats leave in the order they came in. After its second input beat, in_ready stays low until the next tile.
- R6: dc_ready is high only while the block is idle. After a legal coefficient is taken, dc_ready stays low until the cycle after the second output beat has been accepted.
- R7: The bit-depth code dc_bd_sel selects 8 bits with 0, 10 bits with 1 and 12 bits with 2. A request with code 3 is consumed and discarded: the block stays idle and in_ready stays low.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_pix keeps its value.
- R9: During reset dc_ready is high, and in_ready and out_valid are low.
- R10: in_ready is low in the cycle right after a coefficient is taken. It can first rise one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dc_valid | input | 1 | Coefficient request |
| dc_ready | output | 1 | Block is idle and can take a coefficient |
| dc_coef | input | COEF_W | Signed DC coefficient |
| dc_bd_sel | input | 2 | Bit-depth code: 0=8, 1=10, 2=12, 3 not allowed |
| in_valid | input | 1 | Predicted pixel beat is present |
| in_ready | output | 1 | Block takes the pixel beat |
| in_pix | input | PIX_W*8 | Two rows of four predicted pixels |
| out_valid | output | 1 | Reconstructed beat is present |
| out_ready | input | 1 | Downstream takes the beat |
| out_pix | output | PIX_W*8 | Two rows of four reconstructed pixels |

## Verification
Taking an input beat and draining the output register can happen in the same cycle. The second input beat of a tile can be accepted in the very cycle the first output beat leaves. To provoke this, the bench holds in_valid high while out_ready toggles at random. A behavioural model predicts in_ready, out_valid and out_pix for every cycle and compares them, so a beat that is lost, duplicated or stalled when both transfers fall in the same cycle shows up as a mismatch.

// File: rtl/dcq_pkg.sv
package dcq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCALE = 2'd1,
        ST_RUN   = 2'd2
    } dcq_state_e;

    localparam int COS_K   = 11585;
    localparam int RND_SH  = 14;
    localparam int OUT_SH  = 4;
    localparam int RES_W   = 16;

    function automatic logic bd_legal(input logic [1:0] sel);
        return sel != 2'd3;
    endfunction

    function automatic int bd_bits(input logic [1:0] sel);
        case (sel)
            2'd0:    return 8;
            2'd1:    return 10;
            default: return 12;
        endcase
    endfunction

endpackage

// File: rtl/dcq_scale.sv
module dcq_scale #(
    parameter int IN_W  = 20,
    parameter int OUT_W = 20,
    parameter bit FINAL = 1'b0
) (
    input  logic signed [IN_W-1:0]  x,
    output logic signed [OUT_W-1:0] y
);
    import dcq_pkg::*;

    localparam int PW = IN_W + 16;
    localparam logic signed [PW-1:0] K    = PW'(COS_K);
    localparam logic signed [PW-1:0] HALF = PW'(2 ** (RND_SH - 1));
    localparam logic signed [PW-1:0] OUTH = PW'(2 ** (OUT_SH - 1));

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] rnd;

    always_comb begin
        prod = PW'(x) * K;
        rnd  = (prod + HALF) >>> RND_SH;
    end

    generate
        if (FINAL) begin : g_final
            logic signed [PW-1:0] fin;
            always_comb begin
                fin = (rnd + OUTH) >>> OUT_SH;
                y   = OUT_W'(fin);
            end
        end else begin : g_mid
            always_comb y = OUT_W'(rnd);
        end
    endgenerate

endmodule

// File: rtl/dcq_lane.sv
module dcq_lane #(
    parameter int PIX_W = 16,
    parameter int RES_W = 16
) (
    input  logic [PIX_W-1:0]        pix,
    input  logic signed [RES_W-1:0] res,
    input  logic [PIX_W-1:0]        lim,
    output logic [PIX_W-1:0]        q
);
    localparam int SW = ((PIX_W > RES_W) ? PIX_W : RES_W) + 2;

    logic signed [SW-1:0] sum;
    logic signed [SW-1:0] lim_s;

    always_comb begin
        sum   = signed'(SW'(pix)) + SW'(res);
        lim_s = signed'(SW'(lim));
        if (sum < 0) begin
            q = '0;
        end else if (sum > lim_s) begin
            q = lim;
        end else begin
            q = sum[PIX_W-1:0];
        end
    end

endmodule

// File: rtl/dcq_recon.sv
module dcq_recon #(
    parameter int PIX_W         = 16,
    parameter int COEF_W        = 20,
    parameter int ROW_PIX       = 4,
    parameter int TILE_ROWS     = 4,
    parameter int ROWS_PER_BEAT = 2
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     dc_valid,
    output logic                                     dc_ready,
    input  logic signed [COEF_W-1:0]                 dc_coef,
    input  logic [1:0]                               dc_bd_sel,
    input  logic                                     in_valid,
    output logic                                     in_ready,
    input  logic [PIX_W*ROW_PIX*ROWS_PER_BEAT-1:0]   in_pix,
    output logic                                     out_valid,
    input  logic                                     out_ready,
    output logic [PIX_W*ROW_PIX*ROWS_PER_BEAT-1:0]   out_pix
);
    import dcq_pkg::*;

    localparam int LANES = ROW_PIX * ROWS_PER_BEAT;
    localparam int BUS_W = PIX_W * LANES;
    localparam int BEATS = TILE_ROWS / ROWS_PER_BEAT;
    localparam int CW    = $clog2(BEATS + 1);

    typedef struct packed {
        dcq_state_e               st;
        logic signed [COEF_W-1:0] acc;
        logic signed [RES_W-1:0]  res;
        logic [PIX_W-1:0]         lim;
        logic [CW-1:0]            nin;
        logic [CW-1:0]            nout;
        logic                     ov;
        logic [BUS_W-1:0]         opix;
    } regs_t;

    regs_t r_d, r_q;

    logic signed [COEF_W-1:0] t1;
    logic signed [RES_W-1:0]  res_n;
    logic [BUS_W-1:0]         lane_out;
    logic [PIX_W-1:0]         lim_cur;
    logic                     dc_fire, in_fire, out_fire;

    dcq_scale #(.IN_W(COEF_W), .OUT_W(COEF_W), .FINAL(1'b0)) u_scale_a (
        .x (dc_coef),
        .y (t1)
    );

    dcq_scale #(.IN_W(COEF_W), .OUT_W(RES_W), .FINAL(1'b1)) u_scale_b (
        .x (r_q.acc),
        .y (res_n)
    );

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            dcq_lane #(.PIX_W(PIX_W), .RES_W(RES_W)) u_lane (
                .pix (in_pix[i*PIX_W +: PIX_W]),
                .res (r_q.res),
                .lim (r_q.lim),
                .q   (lane_out[i*PIX_W +: PIX_W])
            );
        end
    endgenerate

    always_comb begin
        dc_ready = (r_q.st == ST_IDLE);
        in_ready = (r_q.st == ST_RUN) && (r_q.nin < CW'(BEATS))
                   && (!r_q.ov || out_ready);
        dc_fire  = dc_valid && dc_ready;
        in_fire  = in_valid && in_ready;
        out_fire = r_q.ov && out_ready;
        lim_cur  = r_q.lim;

        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (dc_fire && bd_legal(dc_bd_sel)) begin
                    r_d.acc = t1;
                    r_d.lim = PIX_W'((1 << bd_bits(dc_bd_sel)) - 1);
                    r_d.st  = ST_SCALE;
                end
            end
            ST_SCALE: begin
                r_d.res  = res_n;
                r_d.nin  = '0;
                r_d.nout = '0;
                r_d.ov   = 1'b0;
                r_d.st   = ST_RUN;
            end
            ST_RUN: begin
                if (out_fire) begin
                    r_d.ov   = 1'b0;
                    r_d.nout = r_q.nout + 1'b1;
                    if (r_q.nout == CW'(BEATS - 1)) begin
                        r_d.st = ST_IDLE;
                    end
                end
                if (in_fire) begin
                    r_d.ov   = 1'b1;
                    r_d.opix = lane_out;
                    r_d.nin  = r_q.nin + 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign out_valid = r_q.ov;
    assign out_pix   = r_q.opix;

endmodule

// File: rtl/dcq_recon_chk.sv
module dcq_recon_chk #(
    parameter int PIX_W = 16,
    parameter int LANES = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   dc_valid,
    input logic                   dc_ready,
    input logic [1:0]             dc_bd_sel,
    input logic                   in_ready,
    input logic                   out_valid,
    input logic                   out_ready,
    input logic [PIX_W*LANES-1:0] out_pix,
    input logic [PIX_W-1:0]       lim_q
);
    logic over_lim;

    always_comb begin
        over_lim = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (out_pix[i*PIX_W +: PIX_W] > lim_q) over_lim = 1'b1;
        end
    end

    // R3
    upper_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !over_lim);

    // R8
    hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)));

    // R6
    busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dc_valid && dc_ready && dc_bd_sel != 2'd3) |=> !dc_ready);

    // R7
    illegal_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dc_valid && dc_ready && dc_bd_sel == 2'd3) |=> (dc_ready && !in_ready));

    // R10
    scale_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dc_valid && dc_ready) |=> !in_ready);

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dc_ready |-> (!in_ready && !out_valid));

endmodule

bind dcq_recon dcq_recon_chk #(
    .PIX_W (PIX_W),
    .LANES (ROW_PIX * ROWS_PER_BEAT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dc_valid  (dc_valid),
    .dc_ready  (dc_ready),
    .dc_bd_sel (dc_bd_sel),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_pix   (out_pix),
    .lim_q     (lim_cur)
);

// File: tb/dcq_recon_test.sv
module dcq_recon_test;
    localparam int PIX_W = 16;
    localparam int COEF_W = 20;
    localparam int LANES = 8;
    localparam int BUS_W = PIX_W * LANES;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dc_valid = 1'b0;
    logic dc_ready;
    logic signed [COEF_W-1:0] dc_coef = '0;
    logic [1:0] dc_bd_sel = 2'd0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [BUS_W-1:0] in_pix = '0;
    logic out_valid;
    logic out_ready = 1'b1;
    logic [BUS_W-1:0] out_pix;

    always #10 clk = ~clk;

    dcq_recon uut (
        .clk(clk), .rst_n(rst_n),
        .dc_valid(dc_valid), .dc_ready(dc_ready), .dc_coef(dc_coef), .dc_bd_sel(dc_bd_sel),
        .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix),
        .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix)
    );

    int checks = 0;
    int failures = 0;
    bit bp = 1'b0;

    // behavioural model state
    int ph = 0;
    longint mres = 0;
    longint mlim = 255;
    int mnin = 0, mnout = 0;
    bit mov = 1'b0;
    bit stalled = 1'b0;
    longint mraw [LANES];
    longint mexp [LANES];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic longint residual(input longint c);
        longint t1, t2;
        t1 = (c * 11585 + 8192) >>> 14;
        t2 = (t1 * 11585 + 8192) >>> 14;
        return (t2 + 8) >>> 4;
    endfunction

    always @(negedge clk) begin
        bit inr, ofire, infire;
        if (!rst_n) begin
            ph = 0; mov = 0; mnin = 0; mnout = 0; stalled = 0;
            chk(dc_ready == 1'b1, "R9 dc_ready", dc_ready, 1);
            chk(in_ready == 1'b0, "R9 in_ready", in_ready, 0);
            chk(out_valid == 1'b0, "R9 out_valid", out_valid, 0);
        end else begin
            inr = (ph == 2) && (mnin < 2) && (!mov || out_ready);
            // R6: readiness for a coefficient
            chk(dc_ready == (ph == 0), "R6 dc_ready", dc_ready, ph == 0);
            // R5 / R10: readiness for a pixel beat
            chk(in_ready == inr, (ph == 1) ? "R10 in_ready" : "R5 in_ready", in_ready, inr);
            chk(out_valid == mov, stalled ? "R8 out_valid" : "R5 out_valid", out_valid, mov);
            if (mov && out_valid) begin
                for (int i = 0; i < LANES; i++) begin
                    longint a;
                    a = longint'(out_pix[i*PIX_W +: PIX_W]);
                    // R2: same residual on every lane of both beats
                    chk(a == mexp[i],
                        stalled ? "R8 held pixel" :
                        (mraw[i] > mlim) ? "R3 upper clamp" :
                        (mraw[i] < 0) ? "R4 lower clamp" : "R1/R2 pixel",
                        a, mexp[i]);
                end
            end
            // advance model to the next edge
            ofire = mov && out_ready;
            infire = in_valid && inr;
            stalled = mov && !out_ready;
            case (ph)
                0: if (dc_valid && dc_bd_sel != 2'd3) begin
                    mres = residual(longint'(dc_coef));
                    mlim = (dc_bd_sel == 2'd0) ? 255 : (dc_bd_sel == 2'd1) ? 1023 : 4095;
                    ph = 1;
                end
                1: begin ph = 2; mnin = 0; mnout = 0; mov = 0; end
                default: begin
                    if (ofire) begin
                        mnout++;
                        if (mnout == 2) ph = 0;
                    end
                    if (infire) begin
                        for (int i = 0; i < LANES; i++) begin
                            mraw[i] = longint'(in_pix[i*PIX_W +: PIX_W]) + mres;
                            mexp[i] = (mraw[i] < 0) ? 0 : (mraw[i] > mlim) ? mlim : mraw[i];
                        end
                        mov = 1; mnin++;
                    end else if (ofire) begin
                        mov = 0;
                    end
                end
            endcase
        end
    end

    initial begin
        forever begin
            @(posedge clk); #2;
            out_ready = bp ? ($urandom_range(0, 1) == 1) : 1'b1;
        end
    end

    // pat: 0 random, 1 all at max, 2 all zero
    task automatic tile(input logic signed [COEF_W-1:0] c, input logic [1:0] sel, input int pat);
        bit f;
        int lim;
        lim = (sel == 2'd0) ? 255 : (sel == 2'd1) ? 1023 : 4095;
        dc_valid = 1'b1; dc_coef = c; dc_bd_sel = sel;
        do begin @(negedge clk); f = dc_ready; @(posedge clk); #2; end while (!f);
        dc_valid = 1'b0;
        for (int b = 0; b < 2; b++) begin
            for (int i = 0; i < LANES; i++) begin
                in_pix[i*PIX_W +: PIX_W] = (pat == 1) ? PIX_W'(lim) : (pat == 2) ? '0 :
                                           PIX_W'($urandom_range(0, lim));
            end
            in_valid = 1'b1;
            do begin @(negedge clk); f = in_ready; @(posedge clk); #2; end while (!f);
            in_valid = 1'b0;
        end
    endtask

    initial begin
        #(20 * 100000);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        tile(20'sd1000, 2'd0, 0);        // R1 bd 8
        tile(-20'sd1000, 2'd1, 0);       // R1 bd 10
        tile(20'sd500000, 2'd2, 1);      // R3 clamp at 4095
        tile(20'sd3000, 2'd0, 1);        // R3 clamp at 255
        tile(-20'sd524288, 2'd2, 2);     // R4 clamp at 0
        tile(20'sd0, 2'd1, 0);           // R2 zero residual
        // R7: illegal depth code is dropped
        @(negedge clk); @(posedge clk); #2;
        dc_valid = 1'b1; dc_coef = 20'sd777; dc_bd_sel = 2'd3;
        @(posedge clk); #2 dc_valid = 1'b0;
        @(negedge clk);
        chk(dc_ready == 1'b1, "R7 stays idle", dc_ready, 1);
        chk(in_ready == 1'b0, "R7 no pixel intake", in_ready, 0);
        repeat (3) @(posedge clk);
        #2 bp = 1'b1;
        for (int t = 0; t < 30; t++) begin
            tile(signed'(COEF_W'($urandom)), 2'($urandom_range(0, 2)), (t % 5 == 0) ? 1 : 0);
        end
        bp = 1'b0;
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk(dc_ready == 1'b1, "R6 idle at end", dc_ready, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule